// File: doc/BRIEF.md
# Message-Signalled-Interrupt Capability Register File

This block holds the register set of a PCI message-signalled-interrupt capability as it appears to configuration-space accesses. Software writes through a single port that carries a byte offset measured from the capability start, an access size of two or four bytes, and up to 32 bits of data. A combinational read port returns the field stored at a given offset, zero-extended to 32 bits. The interrupt source reads back decoded status: whether delivery is enabled, how many vectors were granted, and whether a chosen vector is masked.

The layout is not fixed. Three parameters fix the read-only capability bits: the number of vectors the function can request, whether 64-bit message addresses are supported, and whether per-vector masking is supported. Those bits move the upper address, message data, mask and pending registers to different offsets and change the reported capability length. The block guards the read-only control bits against writes. It drops any access that does not land on a defined register and flags it for one cycle.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset every writable field reads zero. The control word reads with bit 0 and bits 6:4 clear, bits 3:1 equal to the vector-capability parameter, bit 7 set when 64-bit addressing is supported, bit 8 set when per-vector masking is supported, and bits 15:9 zero. `msi_enable` is 0 and `vec_count` is 1.
- R2: A 2-byte write at offset 0x2 changes only control bits 0 (enable) and 6:4 (granted-vector exponent). Every other control bit keeps its value. `msi_enable` mirrors bit 0 from the cycle after the write.
- R3: A 4-byte write at offset 0x2 takes the control word from data bits 31:16, under the same protection as R2.
- R4: The lower message address is at offset 0x4 and accepts only 4-byte writes. Its bits 1:0 are always stored as zero.
- R5: With 64-bit addressing the upper address is at 0x8 (4-byte only) and the message data at 0xC. Without it there is no upper address and the message data is at 0x8.
- R6: The message data is 16 bits wide. A 2-byte write stores data bits 15:0. A 4-byte write keeps data bits 15:0 and drops the upper half.
- R7: The mask register exists only with per-vector masking. It is at 0x10 with 64-bit addressing and at 0xC without it, and takes 4-byte writes. The read-only pending register sits 4 bytes above the mask. It reads the `pend_in` value sampled at the previous clock edge.
- R8: `vec_count` equals 2 raised to control bits 6:4 when that field is 5 or less, and 0 for field values 6 and 7.
- R9: `vec_masked` is 1 only when per-vector masking is supported and mask bit `vec_idx` is set. Otherwise it is 0.
- R10: `cap_len` is 0x0A, plus 0x04 with 64-bit addressing, plus 0x0A with per-vector masking.
- R11: A write whose offset names no register for its size, or whose size is neither 2 nor 4, changes no state. It raises `wr_err` for exactly the one cycle that follows it.
- R12: `rd_data` is combinational from `rd_off`. An offset with no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_off | input | 8 | Write byte offset from capability start |
| wr_size | input | 3 | Write size in bytes (2 or 4 valid) |
| wr_data | input | 32 | Write data, little-endian |
| rd_off | input | 8 | Read byte offset |
| rd_data | output | 32 | Field at `rd_off`, zero-extended |
| pend_in | input | 32 | Pending vector bits from the interrupt source |
| vec_idx | input | 5 | Vector number for the mask query |
| vec_masked | output | 1 | Selected vector is masked |
| msi_enable | output | 1 | Delivery enabled |
| vec_count | output | 6 | Number of granted vectors |
| cap_len | output | 8 | Capability length in bytes |
| wr_err | output | 1 | One-cycle flag for a rejected write |

## Verification
The assertions assume that reset holds `wr_en` low, so the first cycle after reset compares against a quiet write port. The properties on control writes also assume that each write lasts one cycle. The bench only pulses `wr_en` for a single cycle and returns it low between accesses. It changes `rd_off`, `vec_idx` and `pend_in` only at the falling edge. Three instances with different capability parameters share one write bus. Every layout variant therefore sees the same accesses, including the offsets that are valid in one layout and undefined in another.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int OFF_W      = 8;
    localparam int DW         = 32;
    localparam int HW         = 16;
    localparam int MAX_VEC    = 32;
    localparam int VEC_IDX_W  = $clog2(MAX_VEC);
    localparam int CNT_W      = VEC_IDX_W + 1;
    localparam int MAX_FIELD  = 5;

    localparam logic [OFF_W-1:0] CTL_OFF     = 8'h02;
    localparam logic [OFF_W-1:0] ADDR_LO_OFF = 8'h04;
    localparam logic [HW-1:0]    CTL_WR_MASK = 16'h0071;
    localparam logic [DW-1:0]    ADDR_LO_MASK = 32'hFFFF_FFFC;

    // one-hot write target index
    localparam int HIT_CTL  = 0;
    localparam int HIT_LO   = 1;
    localparam int HIT_HI   = 2;
    localparam int HIT_DATA = 3;
    localparam int HIT_MASK = 4;
    localparam int NUM_HITS = 5;

    typedef struct packed {
        logic [OFF_W-1:0] data_off;
        logic [OFF_W-1:0] hi_off;
        logic [OFF_W-1:0] mask_off;
        logic [OFF_W-1:0] pend_off;
        logic             hi_ok;
        logic             mask_ok;
        logic [OFF_W-1:0] cap_len;
    } layout_t;

    typedef struct packed {
        logic [HW-1:0] ctl;
        logic [DW-1:0] addr_lo;
        logic [DW-1:0] addr_hi;
        logic [HW-1:0] data;
        logic [DW-1:0] mask;
        logic [DW-1:0] pend;
        logic          err;
    } state_t;

endpackage

// File: rtl/msi_layout.sv
module msi_layout
    import msi_cap_pkg::*;
#(
    parameter bit ADDR64_CAP = 1'b1,
    parameter bit PVM_CAP    = 1'b1
) (
    output layout_t lay
);

    localparam logic [OFF_W-1:0] BASE_LEN = 8'h0A;
    localparam logic [OFF_W-1:0] HI_LEN   = ADDR64_CAP ? 8'h04 : 8'h00;
    localparam logic [OFF_W-1:0] PVM_LEN  = PVM_CAP ? 8'h0A : 8'h00;

    generate
        if (ADDR64_CAP) begin : g_wide
            assign lay.hi_off   = 8'h08;
            assign lay.data_off = 8'h0C;
            assign lay.mask_off = 8'h10;
        end else begin : g_narrow
            assign lay.hi_off   = 8'h00;
            assign lay.data_off = 8'h08;
            assign lay.mask_off = 8'h0C;
        end
    endgenerate

    assign lay.pend_off = lay.mask_off + 8'h04;
    assign lay.hi_ok    = ADDR64_CAP;
    assign lay.mask_ok  = PVM_CAP;
    assign lay.cap_len  = BASE_LEN + HI_LEN + PVM_LEN;

endmodule

// File: rtl/msi_wr_decode.sv
module msi_wr_decode
    import msi_cap_pkg::*;
(
    input  layout_t             lay,
    input  logic                wr_en,
    input  logic [OFF_W-1:0]    wr_off,
    input  logic [2:0]          wr_size,
    output logic [NUM_HITS-1:0] hit,
    output logic                bad
);

    always_comb begin
        hit = '0;
        bad = 1'b0;
        if (wr_en) begin
            if (wr_size == 3'd2) begin
                if (wr_off == CTL_OFF)            hit[HIT_CTL]  = 1'b1;
                else if (wr_off == lay.data_off)  hit[HIT_DATA] = 1'b1;
                else                              bad = 1'b1;
            end else if (wr_size == 3'd4) begin
                if (wr_off == CTL_OFF)                         hit[HIT_CTL]  = 1'b1;
                else if (wr_off == ADDR_LO_OFF)                hit[HIT_LO]   = 1'b1;
                else if (wr_off == lay.data_off)               hit[HIT_DATA] = 1'b1;
                else if (lay.hi_ok && wr_off == lay.hi_off)     hit[HIT_HI]   = 1'b1;
                else if (lay.mask_ok && wr_off == lay.mask_off) hit[HIT_MASK] = 1'b1;
                else                                           bad = 1'b1;
            end else begin
                bad = 1'b1;
            end
        end
    end

endmodule

// File: rtl/msi_vec_status.sv
module msi_vec_status
    import msi_cap_pkg::*;
#(
    parameter bit PVM_CAP = 1'b1
) (
    input  logic                 en_bit,
    input  logic [2:0]           mme_field,
    input  logic [DW-1:0]        mask,
    input  logic [VEC_IDX_W-1:0] vec_idx,
    output logic                 msi_enable,
    output logic [CNT_W-1:0]     vec_count,
    output logic                 vec_masked
);

    assign msi_enable = en_bit;

    always_comb begin
        if (int'(mme_field) > MAX_FIELD) vec_count = '0;
        else                             vec_count = CNT_W'(1) << mme_field;
    end

    generate
        if (PVM_CAP) begin : g_pvm
            assign vec_masked = mask[vec_idx];
        end else begin : g_nopvm
            assign vec_masked = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter logic [2:0] MMC_CAP    = 3'd5,
    parameter bit         ADDR64_CAP = 1'b1,
    parameter bit         PVM_CAP    = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_off,
    input  logic [2:0]  wr_size,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_off,
    output logic [31:0] rd_data,
    input  logic [31:0] pend_in,
    input  logic [4:0]  vec_idx,
    output logic        vec_masked,
    output logic        msi_enable,
    output logic [5:0]  vec_count,
    output logic [7:0]  cap_len,
    output logic        wr_err
);

    localparam logic [HW-1:0] CTL_RST = {7'b0, PVM_CAP, ADDR64_CAP, 3'b0, MMC_CAP, 1'b0};
    localparam state_t ST_RST = '{ctl: CTL_RST, default: '0};

    layout_t             lay;
    logic [NUM_HITS-1:0] hit;
    logic                bad;
    logic [HW-1:0]       ctl_src;
    state_t              st_d, st_q;

    msi_layout #(
        .ADDR64_CAP (ADDR64_CAP),
        .PVM_CAP    (PVM_CAP)
    ) u_layout (
        .lay (lay)
    );

    msi_wr_decode u_decode (
        .lay     (lay),
        .wr_en   (wr_en),
        .wr_off  (wr_off),
        .wr_size (wr_size),
        .hit     (hit),
        .bad     (bad)
    );

    // control source half depends on access size
    assign ctl_src = (wr_size == 3'd4) ? wr_data[DW-1:HW] : wr_data[HW-1:0];

    always_comb begin
        st_d     = st_q;
        st_d.err = bad;
        if (hit[HIT_CTL])  st_d.ctl     = (st_q.ctl & ~CTL_WR_MASK) | (ctl_src & CTL_WR_MASK);
        if (hit[HIT_LO])   st_d.addr_lo = wr_data & ADDR_LO_MASK;
        if (hit[HIT_HI])   st_d.addr_hi = wr_data;
        if (hit[HIT_DATA]) st_d.data    = wr_data[HW-1:0];
        if (hit[HIT_MASK]) st_d.mask    = wr_data;
        st_d.pend = PVM_CAP ? pend_in : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        rd_data = '0;
        if (rd_off == CTL_OFF)                         rd_data = {16'b0, st_q.ctl};
        else if (rd_off == ADDR_LO_OFF)                rd_data = st_q.addr_lo;
        else if (rd_off == lay.data_off)               rd_data = {16'b0, st_q.data};
        else if (lay.hi_ok && rd_off == lay.hi_off)     rd_data = st_q.addr_hi;
        else if (lay.mask_ok && rd_off == lay.mask_off) rd_data = st_q.mask;
        else if (lay.mask_ok && rd_off == lay.pend_off) rd_data = st_q.pend;
    end

    msi_vec_status #(
        .PVM_CAP (PVM_CAP)
    ) u_status (
        .en_bit     (st_q.ctl[0]),
        .mme_field  (st_q.ctl[6:4]),
        .mask       (st_q.mask),
        .vec_idx    (vec_idx),
        .msi_enable (msi_enable),
        .vec_count  (vec_count),
        .vec_masked (vec_masked)
    );

    assign cap_len = lay.cap_len;
    assign wr_err  = st_q.err;

endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk #(
    parameter logic [2:0] MMC_CAP    = 3'd5,
    parameter bit         ADDR64_CAP = 1'b1,
    parameter bit         PVM_CAP    = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [7:0]  wr_off,
    input logic [2:0]  wr_size,
    input logic        wr_d0,
    input logic        wr_d16,
    input logic [7:0]  rd_off,
    input logic [31:0] rd_data,
    input logic        vec_masked,
    input logic        msi_enable,
    input logic [5:0]  vec_count,
    input logic [7:0]  cap_len,
    input logic        wr_err
);

    localparam logic [15:0] RO_MASK = 16'hFF8E;
    localparam logic [15:0] RO_VAL  = {7'b0, PVM_CAP, ADDR64_CAP, 3'b0, MMC_CAP, 1'b0};

    AST_CTL_RO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_off == 8'h02) |-> ((rd_data[15:0] & RO_MASK) == RO_VAL && rd_data[31:16] == 16'h0)); // R1

    AST_CTL_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == 8'h02 && wr_size == 3'd2) |=> (msi_enable == $past(wr_d0))); // R2

    AST_CTL_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == 8'h02 && wr_size == 3'd4) |=> (msi_enable == $past(wr_d16))); // R3

    AST_COUNT_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vec_count) <= 1); // R8

    AST_MASK_NEEDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        vec_masked |-> (cap_len >= 8'h14)); // R9

    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en)); // R11

    AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> ($stable(msi_enable) && $stable(vec_count))); // R11

endmodule

bind msi_cap_regs msi_cap_regs_chk #(
    .MMC_CAP    (MMC_CAP),
    .ADDR64_CAP (ADDR64_CAP),
    .PVM_CAP    (PVM_CAP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_off     (wr_off),
    .wr_size    (wr_size),
    .wr_d0      (wr_data[0]),
    .wr_d16     (wr_data[16]),
    .rd_off     (rd_off),
    .rd_data    (rd_data),
    .vec_masked (vec_masked),
    .msi_enable (msi_enable),
    .vec_count  (vec_count),
    .cap_len    (cap_len),
    .wr_err     (wr_err)
);

// File: tb/msi_cap_regs_bench.sv
module msi_cap_regs_bench;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [2:0]  size;
        logic [7:0]  off;
        logic [31:0] data;
        logic [7:0]  rd;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    // instance A: 64-bit, per-vector masking, 5 in capable field
    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{3'd2, 8'h02, 32'h0000_FFFF, 8'h02, 32'h0000_01FB, 1'b0, 4'd2},  // R2
        '{3'd4, 8'h02, 32'h0030_FFFF, 8'h02, 32'h0000_01BA, 1'b0, 4'd3},  // R3
        '{3'd4, 8'h04, 32'h1234_567F, 8'h04, 32'h1234_567C, 1'b0, 4'd4},  // R4
        '{3'd4, 8'h08, 32'hDEAD_BEEF, 8'h08, 32'hDEAD_BEEF, 1'b0, 4'd5},  // R5
        '{3'd4, 8'h0C, 32'hAAAA_5555, 8'h0C, 32'h0000_5555, 1'b0, 4'd6},  // R6
        '{3'd2, 8'h0C, 32'h0000_1357, 8'h0C, 32'h0000_1357, 1'b0, 4'd6},  // R6
        '{3'd4, 8'h10, 32'h8000_0001, 8'h10, 32'h8000_0001, 1'b0, 4'd7},  // R7
        '{3'd2, 8'h04, 32'h0000_FFFF, 8'h04, 32'h1234_567C, 1'b1, 4'd11}, // R11
        '{3'd1, 8'h02, 32'h0000_0001, 8'h02, 32'h0000_01BA, 1'b1, 4'd11}, // R11
        '{3'd4, 8'h14, 32'hFFFF_FFFF, 8'h10, 32'h8000_0001, 1'b1, 4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_off = '0;
    logic [2:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_off = '0;
    logic [31:0] pend_in = '0;
    logic [4:0]  vec_idx = '0;

    logic [31:0] rd_a, rd_b, rd_c;
    logic        msk_a, msk_b, msk_c, en_a, en_b, en_c, err_a, err_b, err_c;
    logic [5:0]  cnt_a, cnt_b, cnt_c;
    logic [7:0]  len_a, len_b, len_c;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    msi_cap_regs u_msi_cap_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_size(wr_size),
        .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_a), .pend_in(pend_in),
        .vec_idx(vec_idx), .vec_masked(msk_a), .msi_enable(en_a), .vec_count(cnt_a),
        .cap_len(len_a), .wr_err(err_a));

    msi_cap_regs #(.MMC_CAP(3'd0), .ADDR64_CAP(1'b0), .PVM_CAP(1'b1)) u_msi_cap_regs_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_size(wr_size),
        .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_b), .pend_in(pend_in),
        .vec_idx(vec_idx), .vec_masked(msk_b), .msi_enable(en_b), .vec_count(cnt_b),
        .cap_len(len_b), .wr_err(err_b));

    msi_cap_regs #(.MMC_CAP(3'd1), .ADDR64_CAP(1'b0), .PVM_CAP(1'b0)) u_msi_cap_regs_c (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_size(wr_size),
        .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_c), .pend_in(pend_in),
        .vec_idx(vec_idx), .vec_masked(msk_c), .msi_enable(en_c), .vec_count(cnt_c),
        .cap_len(len_c), .wr_err(err_c));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] sz, input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_size = sz; wr_off = off; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_at(input logic [7:0] off);
        rd_off = off;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_at(8'h02);
        chk("R1 ctl A", rd_a, 32'h0000_018A);
        chk("R1 ctl B", rd_b, 32'h0000_0100);
        chk("R1 ctl C", rd_c, 32'h0000_0002);
        rd_at(8'h04);
        chk("R1 addr_lo A", rd_a, 32'h0);
        rd_at(8'h0C);
        chk("R1 data A", rd_a, 32'h0);
        chk("R1 enable A", {31'b0, en_a}, 32'h0);
        chk("R1 count A", {26'b0, cnt_a}, 32'h1);
        chk("R1 err A", {31'b0, err_a}, 32'h0);
        // R10 length per layout
        chk("R10 len A", {24'b0, len_a}, 32'h18);
        chk("R10 len B", {24'b0, len_b}, 32'h14);
        chk("R10 len C", {24'b0, len_c}, 32'h0A);

        // table walk on instance A
        for (int i = 0; i < NV; i++) begin
            do_wr(TBL[i].size, TBL[i].off, TBL[i].data);
            chk($sformatf("R%0d err row %0d", TBL[i].req, i), {31'b0, err_a}, {31'b0, TBL[i].err});
            rd_at(TBL[i].rd);
            chk($sformatf("R%0d read row %0d", TBL[i].req, i), rd_a, TBL[i].exp);
        end
        @(negedge clk);
        chk("R11 err one cycle", {31'b0, err_a}, 32'h0);

        // R8 granted vector count for every field value
        for (int f = 0; f < 8; f++) begin
            do_wr(3'd2, 8'h02, 32'(f) << 4);
            chk($sformatf("R8 count f=%0d", f), {26'b0, cnt_a}, (f <= 5) ? (32'h1 << f) : 32'h0);
        end
        // R2 enable bit
        do_wr(3'd2, 8'h02, 32'h0000_0001);
        chk("R2 enable set", {31'b0, en_a}, 32'h1);
        rd_at(8'h02);
        chk("R2 ctl after enable", rd_a, 32'h0000_018B);

        // R9 mask query on A (mask = 8000_0001)
        vec_idx = 5'd0; #1;
        chk("R9 A idx0", {31'b0, msk_a}, 32'h1);
        vec_idx = 5'd1; #1;
        chk("R9 A idx1", {31'b0, msk_a}, 32'h0);
        vec_idx = 5'd31; #1;
        chk("R9 A idx31", {31'b0, msk_a}, 32'h1);

        // R5 narrow layout: data at 0x8
        do_wr(3'd4, 8'h08, 32'h1111_2222);
        rd_at(8'h08);
        chk("R5 B data at 8", rd_b, 32'h0000_2222);
        chk("R5 C data at 8", rd_c, 32'h0000_2222);
        chk("R5 B no err", {31'b0, err_b}, 32'h0);

        // R7 narrow mask at 0xC; C has no mask so R11 error there
        do_wr(3'd4, 8'h0C, 32'h0000_00F0);
        chk("R11 C mask offset rejected", {31'b0, err_c}, 32'h1);
        rd_at(8'h0C);
        chk("R7 B mask at C", rd_b, 32'h0000_00F0);
        chk("R12 C undefined read", rd_c, 32'h0);
        vec_idx = 5'd4; #1;
        chk("R9 B idx4", {31'b0, msk_b}, 32'h1);
        chk("R9 C never masked", {31'b0, msk_c}, 32'h0);

        // R7 pending mirror
        @(negedge clk);
        pend_in = 32'hCAFE_0001;
        @(negedge clk);
        rd_at(8'h14);
        chk("R7 A pending", rd_a, 32'hCAFE_0001);
        rd_at(8'h10);
        chk("R7 B pending", rd_b, 32'hCAFE_0001);
        chk("R12 C pending absent", rd_c, 32'h0);
        rd_at(8'h30);
        chk("R12 A undefined read", rd_a, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule